// File: doc/BRIEF.md
# Latching Maskable Interrupt Aggregator

This block gathers nine interrupt request conditions into one interrupt line. The conditions are five general-purpose input pins, a write-sequencer busy flag, a clock-lock indication, a microphone-present detector and a microphone-short detector. Each condition can have its sense inverted. The adjusted condition then sets a sticky status bit. Reading the status word returns the latched bits and clears them. A condition that is still active sets its bit again straight away.

A mask word chooses which status bits reach the interrupt line. Masked bits still record events, so software can poll them. The line is the OR of the unmasked status bits, and it can be driven active high or active low. Software reaches the status, mask and polarity words through a small register port. Reads return data one cycle after the request.

Top module: `irq_aggregator`

## Requirements
- R1: Status bit positions are: bits 0 to 4 for gpio_i[0] to gpio_i[4], bit 5 for seq_busy_i, bit 6 for lock_i, bit 7 for mic_det_i and bit 8 for mic_short_i. A bit sets on any rising clock edge where its polarity-adjusted source is high. GPIO pins pass through a two-flop synchronizer first, so their bits set two edges later than the other sources.
- R2: A set status bit stays set after its source goes inactive, until the status word is read.
- R3: A read at address 0 returns the status word in bits 8:0, with zeros above, in the cycle after the request. The same edge clears the status word.
- R4: irq_o is at its active level whenever at least one status bit is set whose mask bit is 0.
- R5: Address 1 holds the mask word in bits 8:0, where a 1 masks a source. A masked source still sets its status bit but leaves irq_o at its idle level.
- R6: Address 2 bits 0 to 4 invert the five GPIO sources, and bits 6, 7 and 8 invert the lock, microphone-present and microphone-short sources. Bit 5 cannot be written: it reads 0, and the busy flag is never inverted.
- R7: If a source is active in the same cycle that a status read clears the word, its bit is left set.
- R8: Address 2 bit 9 selects the output polarity. 0 means irq_o is active high and 1 means it is active low.
- R9: Reset clears the status word, sets every mask bit to 1 and clears every polarity bit, so irq_o starts low.
- R10: Reads at addresses 1 and 2 return the register contents one cycle later. Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gpio_i | input | 5 | Asynchronous GPIO interrupt sources |
| seq_busy_i | input | 1 | Write-sequencer busy flag (synchronous) |
| lock_i | input | 1 | Clock-lock indication (synchronous) |
| mic_det_i | input | 1 | Microphone-present detect (synchronous) |
| mic_short_i | input | 1 | Microphone-short detect (synchronous) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, valid one cycle after reg_rd_i |
| irq_o | output | 1 | Combined interrupt output |

## Verification
A new event and the clear-on-read of the status word can arrive on the same clock edge. The bench sets up this clash by raising the busy flag in exactly the cycle that carries a status read request, then dropping it. It judges the result in two steps. The returned data must show the word as it was before that edge. A second read must still report the busy bit, and irq_o must stay active in between. A held lock condition that survives back-to-back reads is checked the same way.

// File: rtl/irq_agg_pkg.sv
// Shared definitions for the interrupt aggregator: register selects and
// the source-invert capability map. Assumes GPIO sources occupy the low bits.
package irq_agg_pkg;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_POL    = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    // Invert capability per source: every GPIO, then busy (fixed), lock, detect, short.
    function automatic logic [31:0] inv_capable(input int n_gpio);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < n_gpio; i++) m[i] = 1'b1;
        m[n_gpio + 1] = 1'b1;
        m[n_gpio + 2] = 1'b1;
        m[n_gpio + 3] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/irq_input_sync.sv
// Multi-stage synchronizer for asynchronous inputs.
// Assumes inputs are level signals held longer than STAGES clock cycles.
module irq_input_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift each stage one step toward the output.
            always_ff @(posedge clk) begin
                if (!rst_n)      stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= d_i;
                else             stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/irq_status_latch.sv
// Sticky status word: bits set from active conditions and clear on a read
// strobe. A set in the clearing cycle takes precedence.
module irq_status_latch #(
    parameter int N = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] status_o
);

    // Update the latched word: clear on read, then OR in new conditions.
    always_ff @(posedge clk) begin
        if (!rst_n) status_o <= '0;
        else        status_o <= (clr_i ? '0 : status_o) | set_i;
    end

    // R1 and R7: an active condition is latched on the next edge, even when a clear happens in the same cycle
    p_set_latches_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((status_o & $past(set_i)) == $past(set_i)));

    // R2: without a clear no set bit is lost
    p_sticky_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i) |=> ((status_o & $past(status_o)) == $past(status_o)));

    // R3: a clear with no active condition empties the word
    p_clear_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(|set_i)) |=> (status_o == '0));

endmodule

// File: rtl/irq_regs.sv
// Register port: mask and polarity storage, read mux with one-cycle latency,
// and the clear strobe for the status word. Assumes one access per cycle.
module irq_regs
    import irq_agg_pkg::*;
#(
    parameter int N       = 9,
    parameter int N_GPIO  = 5,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [1:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [N-1:0]      status_i,
    output logic [N-1:0]      mask_o,
    output logic [N-1:0]      inv_o,
    output logic              out_pol_o,
    output logic              status_clr_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam logic [N-1:0] INV_OK = N'(inv_capable(N_GPIO));

    reg_sel_e sel;
    logic     unused_wdata;

    assign sel          = reg_sel_e'(addr_i);
    assign status_clr_o = rd_i && (sel == SEL_STATUS);
    assign unused_wdata = ^wdata_i[DATA_W-1:N+1];

    // Mask word storage, all sources masked out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                        mask_o <= '1;
        else if (wr_i && sel == SEL_MASK)  mask_o <= wdata_i[N-1:0];
    end

    // Invert and output-polarity storage; non-invertible positions stay 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_o     <= '0;
            out_pol_o <= 1'b0;
        end else if (wr_i && sel == SEL_POL) begin
            inv_o     <= wdata_i[N-1:0] & INV_OK;
            out_pol_o <= wdata_i[N];
        end
    end

    // Registered read mux.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_o <= '0;
        else if (rd_i) begin
            unique case (sel)
                SEL_STATUS: rdata_o <= {{(DATA_W-N){1'b0}}, status_i};
                SEL_MASK:   rdata_o <= {{(DATA_W-N){1'b0}}, mask_o};
                SEL_POL:    rdata_o <= {{(DATA_W-N-1){1'b0}}, out_pol_o, inv_o};
                default:    rdata_o <= '0;
            endcase
        end
    end

    // R9: reset leaves everything masked and all polarity bits clear
    p_reset_values_r9: assert property (@(posedge clk)
        !rst_n |=> (mask_o == '1 && inv_o == '0 && !out_pol_o));

    // R10: a mask read returns the pre-edge mask one cycle later
    p_mask_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && sel == SEL_MASK) |=> (rdata_o[N-1:0] == $past(mask_o)));

    // R6: the busy flag is never inverted
    p_busy_not_inv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel == SEL_POL) |=> !inv_o[N_GPIO]);

endmodule

// File: rtl/irq_aggregator.sv
// Interrupt aggregator top: synchronizes GPIO sources, applies per-source
// polarity, latches sticky status and drives one masked, polarity-selectable
// interrupt line. Assumes non-GPIO sources are already in the clk domain.
module irq_aggregator #(
    parameter int N_GPIO      = 5,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_GPIO-1:0] gpio_i,
    input  logic              seq_busy_i,
    input  logic              lock_i,
    input  logic              mic_det_i,
    input  logic              mic_short_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [1:0]        reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);

    localparam int N = N_GPIO + 4;

    logic [N_GPIO-1:0] gpio_s;
    logic [N-1:0]      raw_src, cond, status, mask, inv;
    logic              out_pol, status_clr;

    irq_input_sync #(.WIDTH(N_GPIO), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(gpio_i), .q_o(gpio_s)
    );

    assign raw_src = {mic_short_i, mic_det_i, lock_i, seq_busy_i, gpio_s};
    assign cond    = raw_src ^ inv;

    irq_status_latch #(.N(N)) u_status (
        .clk(clk), .rst_n(rst_n), .set_i(cond), .clr_i(status_clr),
        .status_o(status)
    );

    irq_regs #(.N(N), .N_GPIO(N_GPIO), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .rd_i(reg_rd_i),
        .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .status_i(status),
        .mask_o(mask), .inv_o(inv), .out_pol_o(out_pol),
        .status_clr_o(status_clr), .rdata_o(reg_rdata_o)
    );

    // Combine unmasked status bits and apply the output polarity.
    assign irq_o = (|(status & ~mask)) ^ out_pol;

    // R5: right after all sources are masked the line sits at its idle level
    p_all_masked_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == 2'd1 && reg_wdata_i[N-1:0] == '1)
        |=> (irq_o == out_pol));

endmodule

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  gpio = '0;
    logic        seq_busy = 1'b0, lock = 1'b0, mic_det = 1'b0, mic_short = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_aggregator dut (
        .clk(clk), .rst_n(rst_n), .gpio_i(gpio), .seq_busy_i(seq_busy),
        .lock_i(lock), .mic_det_i(mic_det), .mic_short_i(mic_short),
        .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic set_src(input logic [8:0] p);
        gpio = p[4:0]; seq_busy = p[5]; lock = p[6]; mic_det = p[7]; mic_short = p[8];
    endtask

    task automatic pulse(input logic [8:0] p);
        @(negedge clk);
        set_src(p);
        repeat (3) @(negedge clk);
        set_src('0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 / R10: reset state
        chk("R9 irq idle", irq, 0);
        rd(2'd0, d); chk("R9 status", d, 0);
        rd(2'd1, d); chk("R9 mask", d, 16'h01FF);
        rd(2'd2, d); chk("R9 pol", d, 0);
        rd(2'd3, d); chk("R10 addr3", d, 0);

        // R1 R2 R3 R4 R5: sweep every source pattern against two masks
        for (int p = 0; p < 512; p++) begin
            pulse(9'(p));
            wr(2'd1, 16'(p));
            chk("R5 masked pending", irq, 0);
            wr(2'd1, 16'(~p & 9'h1FF));
            chk("R4 unmasked pending", irq, (p != 0));
            rd(2'd0, d); chk("R1 R2 status", d, 16'(p));
            chk("R3 irq after clear", irq, 0);
            rd(2'd0, d); chk("R3 cleared", d, 0);
            wr(2'd1, 16'h01FF);
        end

        // R1: GPIO path takes two edges through the synchronizer
        @(negedge clk); gpio = 5'b00100;
        @(negedge clk); gpio = 5'b00000;
        repeat (3) @(negedge clk);
        rd(2'd0, d); chk("R1 gpio short pulse", d, 16'h0004);

        // R6: invert each source in turn while all sources idle
        for (int i = 0; i < 9; i++) begin
            wr(2'd2, 16'(1 << i));
            rd(2'd2, d); chk("R6 pol readback", d, (i == 5) ? 0 : 16'(1 << i));
            wr(2'd2, 16'h0000);
            rd(2'd0, d); chk("R6 inverted idle sets", d, (i == 5) ? 0 : 16'(1 << i));
            rd(2'd0, d); chk("R6 no set after restore", d, 0);
        end
        // R6: inverted source goes quiet while its raw input is high
        wr(2'd2, 16'h0040);
        @(negedge clk); lock = 1'b1;
        rd(2'd0, d);
        rd(2'd0, d); chk("R6 inverted active input quiet", d, 0);
        @(negedge clk); lock = 1'b0;
        wr(2'd2, 16'h0000);
        rd(2'd0, d);

        // R8: active-low output
        wr(2'd2, 16'h0200);
        chk("R8 idle level low-active", irq, 1);
        wr(2'd1, 16'h00FF);
        pulse(9'h100);
        chk("R8 asserted low", irq, 0);
        rd(2'd0, d); chk("R8 status", d, 16'h0100);
        chk("R8 released", irq, 1);
        wr(2'd2, 16'h0000);
        rd(2'd2, d); chk("R10 pol readback", d, 0);

        // R7: event in the same cycle as the clearing read
        wr(2'd1, 16'h01DF);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 2'd0; seq_busy = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0; seq_busy = 1'b0;
        chk("R7 read shows old word", reg_rdata, 0);
        chk("R7 irq active", irq, 1);
        rd(2'd0, d); chk("R7 set survived clear", d, 16'h0020);
        chk("R7 irq idle", irq, 0);

        // R7 / R4: held condition re-sets right after each read
        wr(2'd1, 16'h01BF);
        @(negedge clk); lock = 1'b1;
        repeat (2) @(negedge clk);
        rd(2'd0, d); chk("R7 held first read", d, 16'h0040);
        chk("R4 held irq", irq, 1);
        rd(2'd0, d); chk("R7 held second read", d, 16'h0040);
        lock = 1'b0;
        rd(2'd0, d); chk("R2 last set kept", d, 16'h0040);
        rd(2'd0, d); chk("R3 finally clear", d, 0);
        chk("R4 irq idle", irq, 0);

        // R10: mask readback
        wr(2'd1, 16'h0155);
        rd(2'd1, d); chk("R10 mask readback", d, 16'h0155);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule